// File: doc/BRIEF.md
# Mailbox Backlight Command Sequencer

This block turns one backlight request into the ordered register traffic that an embedded display microcontroller expects on its mailbox. A request carries an 8-bit brightness level, a frame ramp and a controller identifier, and is launched by a one-cycle start strobe. The sequencer then acts as a master on a simple register bus. It performs exactly one access at a time, and each access completes when the slave returns ready.

The traffic has two chained mailbox commands. The first selects the display pipe and rings a doorbell bit. The sequencer then polls that bit, with a fixed idle gap between reads, until the microcontroller clears it. Only then does it load the user level and the ramp and issue the backlight-set command with a second doorbell. Finally it mirrors the level into a scratch register with a read-modify-write. If the first doorbell is never cleared within the poll budget, the sequence stops and a timeout pulse is reported.

Top module: `bl_mbox_seq`

## Requirements
- R1: While reset is held, and afterwards until a start is seen, `busy`, `bus_req`, `done` and `timeout` are all low.
- R2: After start, the first write puts 0x0000FFFF at the data address (0x10). The second write puts the command word {16'h0, ctrl_id, 8'h66} at the command address (0x14): opcode in bits 7:0, controller ID in bits 15:8.
- R3: The doorbell is rung by writing 1 at the doorbell address (0x18). The doorbell address is then read; polling ends on the first read whose bit 0 is 0. Successive reads are separated by POLL_GAP idle cycles, and at most POLL_MAX reads are made.
- R4: After the doorbell clears, the user-level address (0x1C) is written with the 17-bit value u = ((level*0x10101)>>8) + bit 7 of that shifted value, zero-extended.
- R5: The next write puts the frame ramp, zero-extended, at the data address (0x10). The value written is 0 when ctrl_id is 0.
- R6: Then {16'h0, ctrl_id, 8'h67} is written to the command address, followed by a second write of 1 to the doorbell address. The second doorbell is not polled.
- R7: The scratch address (0x20) is read, and then written back with bits 15:8 replaced by the level and all other bits unchanged.
- R8: If POLL_MAX reads all return bit 0 set, `timeout` pulses for one cycle, no further bus access is made, and `busy` falls.
- R9: While `bus_req` is high and `bus_ready` is low, `bus_we`, `bus_addr` and `bus_wdata` stay stable and `bus_req` stays high.
- R10: A start strobe while `busy` is high is ignored. The running sequence keeps its captured inputs and no second sequence follows.
- R11: `done` pulses for exactly one cycle in the cycle after the scratch write is accepted. `done` and `timeout` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| level | input | LVL_W | Brightness level |
| ramp | input | RAMP_W | Frame ramp value |
| ctrl_id | input | ID_W | Controller identifier |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W | Access address |
| bus_wdata | output | DATA_W | Write data |
| bus_rdata | input | DATA_W | Read data, valid with bus_ready |
| bus_ready | input | 1 | Access accepted on this clock edge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence finished pulse |
| timeout | output | 1 | First doorbell not cleared pulse |

## Verification
The hardest situations to reach from the ports are the edges of the poll budget. In one, the doorbell clears on exactly the last permitted read. In the other, it stays set through that read and the sequence must abort. The bench's bus slave clears the doorbell after a programmable number of reads, and directed runs set that number to POLL_MAX-1 and to POLL_MAX. The slave also inserts random ready stalls on every access, so that the hold-stable rule and the one-access-at-a-time order are checked under backpressure.

// File: rtl/bl_mbox_pkg.sv
package bl_mbox_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_BOUND, S_PIPE, S_RING1, S_POLL, S_GAP,
    S_USER, S_RAMP, S_SET, S_RING2, S_SCR_RD, S_SCR_WR
  } seq_state_t;

  localparam logic [7:0] OP_PIPE_SEL = 8'h66;
  localparam logic [7:0] OP_BL_SET   = 8'h67;
endpackage

// File: rtl/bl_level_conv.sv
// Expands an LVL_W-bit level to a (2*LVL_W+1)-bit user level with rounding.
module bl_level_conv #(
  parameter int LVL_W = 8
) (
  input  logic [LVL_W-1:0]   lvl,
  output logic [2*LVL_W:0]   user_lvl
);
  localparam int UW = 2*LVL_W + 1;
  logic [2*LVL_W-1:0] rep;
  assign rep      = {lvl, lvl};
  assign user_lvl = UW'(rep) + UW'(lvl[LVL_W-1]);
endmodule

// File: rtl/bl_poll_timer.sv
// Gap counter between doorbell reads and poll budget counter.
module bl_poll_timer #(
  parameter int POLL_MAX = 800,
  parameter int POLL_GAP = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic gap_en,
  input  logic miss,
  output logic gap_done,
  output logic last_poll
);
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int GW = $clog2(POLL_GAP + 1);

  logic [PW-1:0] poll_q, poll_d;
  logic [GW-1:0] gap_q, gap_d;

  assign gap_done  = gap_en && (gap_q == GW'(POLL_GAP - 1));
  assign last_poll = (poll_q == PW'(POLL_MAX - 1));

  always_comb begin
    poll_d = poll_q;
    if (clr)       poll_d = '0;
    else if (miss) poll_d = poll_q + PW'(1);
    gap_d = gap_q;
    if (clr || gap_done) gap_d = '0;
    else if (gap_en)     gap_d = gap_q + GW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poll_q <= '0;
      gap_q  <= '0;
    end else begin
      poll_q <= poll_d;
      gap_q  <= gap_d;
    end
  end
endmodule

// File: rtl/bl_mbox_seq.sv
module bl_mbox_seq
  import bl_mbox_pkg::*;
#(
  parameter int          LVL_W    = 8,
  parameter int          RAMP_W   = 16,
  parameter int          ID_W     = 8,
  parameter int          ADDR_W   = 8,
  parameter int          DATA_W   = 32,
  parameter int          POLL_MAX = 800,
  parameter int          POLL_GAP = 8,
  parameter int          SCR_LSB  = 8,
  parameter logic [7:0]  A_DATA1  = 8'h10,
  parameter logic [7:0]  A_CMD    = 8'h14,
  parameter logic [7:0]  A_DB     = 8'h18,
  parameter logic [7:0]  A_USER   = 8'h1C,
  parameter logic [7:0]  A_SCR    = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LVL_W-1:0]  level,
  input  logic [RAMP_W-1:0] ramp,
  input  logic [ID_W-1:0]   ctrl_id,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ready,
  output logic              busy,
  output logic              done,
  output logic              timeout
);
  localparam int UW = 2*LVL_W + 1;
  localparam logic [15:0] BOUNDARY = 16'hFFFF;

  seq_state_t        state_q, state_d;
  logic [LVL_W-1:0]  lvl_q;
  logic [RAMP_W-1:0] ramp_q;
  logic [ID_W-1:0]   id_q;
  logic [DATA_W-1:0] scr_q, scr_new;
  logic              done_q, done_d, to_q, to_d;
  logic              cap_en, scr_en;
  logic              clr, gap_en, miss, gap_done, last_poll;
  logic [UW-1:0]     user_lvl;
  logic [RAMP_W-1:0] ramp_eff;

  bl_level_conv #(.LVL_W(LVL_W)) u_conv (.lvl(lvl_q), .user_lvl(user_lvl));

  bl_poll_timer #(.POLL_MAX(POLL_MAX), .POLL_GAP(POLL_GAP)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(clr), .gap_en(gap_en), .miss(miss),
    .gap_done(gap_done), .last_poll(last_poll)
  );

  assign ramp_eff = (id_q == '0) ? '0 : ramp_q;

  always_comb begin
    scr_new = scr_q;
    scr_new[SCR_LSB +: LVL_W] = lvl_q;
  end

  // next-state and bus drive
  always_comb begin
    state_d   = state_q;
    cap_en    = 1'b0;
    scr_en    = 1'b0;
    done_d    = 1'b0;
    to_d      = 1'b0;
    clr       = 1'b0;
    gap_en    = 1'b0;
    miss      = 1'b0;
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    case (state_q)
      S_IDLE: if (start) begin
        cap_en  = 1'b1;
        state_d = S_BOUND;
      end
      S_BOUND: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_DATA1); bus_wdata = DATA_W'(BOUNDARY);
        if (bus_ready) state_d = S_PIPE;
      end
      S_PIPE: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_CMD); bus_wdata = DATA_W'({id_q, OP_PIPE_SEL});
        if (bus_ready) state_d = S_RING1;
      end
      S_RING1: begin
        bus_req = 1'b1; bus_we = 1'b1; clr = 1'b1;
        bus_addr = ADDR_W'(A_DB); bus_wdata = DATA_W'(1);
        if (bus_ready) state_d = S_POLL;
      end
      S_POLL: begin
        bus_req = 1'b1;
        bus_addr = ADDR_W'(A_DB);
        if (bus_ready) begin
          if (!bus_rdata[0]) state_d = S_USER;
          else if (last_poll) begin
            to_d    = 1'b1;
            state_d = S_IDLE;
          end else begin
            miss    = 1'b1;
            state_d = S_GAP;
          end
        end
      end
      S_GAP: begin
        gap_en = 1'b1;
        if (gap_done) state_d = S_POLL;
      end
      S_USER: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_USER); bus_wdata = DATA_W'(user_lvl);
        if (bus_ready) state_d = S_RAMP;
      end
      S_RAMP: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_DATA1); bus_wdata = DATA_W'(ramp_eff);
        if (bus_ready) state_d = S_SET;
      end
      S_SET: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_CMD); bus_wdata = DATA_W'({id_q, OP_BL_SET});
        if (bus_ready) state_d = S_RING2;
      end
      S_RING2: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_DB); bus_wdata = DATA_W'(1);
        if (bus_ready) state_d = S_SCR_RD;
      end
      S_SCR_RD: begin
        bus_req = 1'b1;
        bus_addr = ADDR_W'(A_SCR);
        if (bus_ready) begin
          scr_en  = 1'b1;
          state_d = S_SCR_WR;
        end
      end
      S_SCR_WR: begin
        bus_req = 1'b1; bus_we = 1'b1;
        bus_addr = ADDR_W'(A_SCR); bus_wdata = scr_new;
        if (bus_ready) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  assign busy    = (state_q != S_IDLE);
  assign done    = done_q;
  assign timeout = to_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q  <= '0;
      ramp_q <= '0;
      id_q   <= '0;
    end else if (cap_en) begin
      lvl_q  <= level;
      ramp_q <= ramp;
      id_q   <= ctrl_id;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      scr_q <= '0;
    else if (scr_en) scr_q <= bus_rdata;
  end
endmodule

// File: rtl/bl_mbox_seq_chk.sv
module bl_mbox_seq_chk #(
  parameter int         ADDR_W   = 8,
  parameter int         DATA_W   = 32,
  parameter int         POLL_MAX = 800,
  parameter logic [7:0] A_DB     = 8'h18
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              bus_req,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_ready,
  input logic              busy,
  input logic              done,
  input logic              timeout
);
  localparam int CW = $clog2(POLL_MAX + 2) + 1;
  logic [CW-1:0] polls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) polls <= '0;
    else if (start && !busy) polls <= '0;
    else if (bus_req && bus_ready && !bus_we && bus_addr == ADDR_W'(A_DB))
      polls <= polls + CW'(1);
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bus_req);
  a_r3_poll_budget: assert property (@(posedge clk) disable iff (!rst_n)
    polls <= CW'(POLL_MAX));
  a_r8_timeout_stops: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> !busy && !bus_req);
  a_r9_hold_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ready |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));
  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
endmodule

bind bl_mbox_seq bl_mbox_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .POLL_MAX(POLL_MAX), .A_DB(A_DB)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .bus_req(bus_req), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .busy(busy), .done(done), .timeout(timeout)
);

// File: tb/bl_mbox_seq_test.sv
module bl_mbox_seq_test;
  localparam int PM = 12;
  localparam int PG = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  level = '0;
  logic [15:0] ramp = '0;
  logic [7:0]  ctrl_id = '0;
  logic        bus_req, bus_we, bus_ready, busy, done, timeout;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  always #2 clk = ~clk;

  bl_mbox_seq #(.POLL_MAX(PM), .POLL_GAP(PG)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .level(level), .ramp(ramp),
    .ctrl_id(ctrl_id), .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .busy(busy), .done(done), .timeout(timeout)
  );

  // bus slave model
  logic        rdy = 1'b0;
  logic        db;
  logic [31:0] scr;
  int          ack_n = 0;
  int          db_rd, db_reads, wr_n, viol;
  logic [7:0]  wr_a [0:511];
  logic [31:0] wr_d [0:511];
  logic        p_stall;
  logic [7:0]  p_addr;
  logic [31:0] p_wdata;
  logic        p_we;

  assign bus_ready = bus_req & rdy;
  assign bus_rdata = (bus_addr == 8'h18) ? {31'b0, db} :
                     (bus_addr == 8'h20) ? scr : 32'h0;

  always @(negedge clk) rdy <= ($urandom % 4) != 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      db <= 1'b0; scr <= 32'hA5C3_5A3C; db_rd <= 0; db_reads <= 0;
      wr_n <= 0; viol <= 0; p_stall <= 1'b0;
      p_addr <= '0; p_wdata <= '0; p_we <= 1'b0;
    end else begin
      if (p_stall && (!bus_req || bus_addr != p_addr || bus_wdata != p_wdata || bus_we != p_we))
        viol <= viol + 1;
      p_stall <= bus_req && !rdy;
      p_addr <= bus_addr; p_wdata <= bus_wdata; p_we <= bus_we;
      if (bus_req && rdy) begin
        if (bus_we) begin
          wr_a[wr_n] <= bus_addr; wr_d[wr_n] <= bus_wdata; wr_n <= wr_n + 1;
          if (bus_addr == 8'h18 && bus_wdata[0]) begin
            db <= (ack_n != 0); db_rd <= 0;
          end
          if (bus_addr == 8'h20) scr <= bus_wdata;
        end else if (bus_addr == 8'h18) begin
          db_reads <= db_reads + 1;
          db_rd <= db_rd + 1;
          if (db_rd + 1 >= ack_n) db <= 1'b0;
        end
      end
    end
  end

  int total = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] user_of(input logic [7:0] l);
    logic [31:0] t;
    t = (32'(l) * 32'h10101) >> 8;
    return t + 32'(t[7]);
  endfunction

  task automatic run(input logic [7:0] l, input logic [15:0] r, input logic [7:0] id,
                     input int ack, input bit inject);
    int bw, br, cyc, nexp, exp_r;
    bit to;
    logic [31:0] old_scr, exp_scr;
    logic [7:0]  ea [0:7];
    logic [31:0] ed [0:7];
    bw = wr_n; br = db_reads; old_scr = scr; ack_n = ack;
    to = (ack >= PM);
    @(negedge clk);
    level = l; ramp = r; ctrl_id = id; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      repeat (4) @(negedge clk);
      level = ~l; ramp = ~r; ctrl_id = id + 8'd1; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!(done || timeout) && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == !to, "R11 done", 32'(done), 32'(!to));
    chk(timeout == to, "R8 timeout", 32'(timeout), 32'(to));
    exp_scr = old_scr;
    exp_scr[15:8] = l;
    ea[0] = 8'h10; ed[0] = 32'h0000FFFF;                  // R2
    ea[1] = 8'h14; ed[1] = {16'h0, id, 8'h66};            // R2
    ea[2] = 8'h18; ed[2] = 32'h1;                         // R3
    ea[3] = 8'h1C; ed[3] = user_of(l);                    // R4
    ea[4] = 8'h10; ed[4] = (id == 0) ? 32'h0 : 32'(r);    // R5
    ea[5] = 8'h14; ed[5] = {16'h0, id, 8'h67};            // R6
    ea[6] = 8'h18; ed[6] = 32'h1;                         // R6
    ea[7] = 8'h20; ed[7] = exp_scr;                       // R7
    nexp = to ? 3 : 8;
    exp_r = to ? PM : ((ack == 0) ? 1 : ack + 1);
    @(negedge clk);
    chk(!done && !timeout, "R11 single-cycle pulse", 32'({done, timeout}), 32'h0);
    chk(!busy, "R8 busy falls", 32'(busy), 32'h0);
    repeat (6) @(negedge clk);
    chk(wr_n - bw == nexp, "R10 write count", 32'(wr_n - bw), 32'(nexp));
    for (int i = 0; i < nexp; i++) begin
      chk(wr_a[bw + i] == ea[i], "R2-order addr", 32'(wr_a[bw + i]), 32'(ea[i]));
      chk(wr_d[bw + i] == ed[i], "R4 R5 R6 data", wr_d[bw + i], ed[i]);
    end
    chk(db_reads - br == exp_r, "R3 poll reads", 32'(db_reads - br), 32'(exp_r));
    if (!to) chk(scr == exp_scr, "R7 scratch", scr, exp_scr);
    else chk(scr == old_scr, "R8 scratch untouched", scr, old_scr);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !timeout, "R1 in reset",
        32'({busy, bus_req, done, timeout}), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !bus_req && !done && !timeout, "R1 after reset",
        32'({busy, bus_req, done, timeout}), 32'h0);
    // directed corners
    run(8'h00, 16'h1234, 8'h00, 0, 1'b0);       // R4 zero level, R5 zero id
    run(8'hFF, 16'h0F0F, 8'h03, 2, 1'b0);       // R4 full level
    run(8'h80, 16'hBEEF, 8'h00, 1, 1'b0);       // R5 ramp forced to zero
    run(8'hEF, 16'h0042, 8'h01, PM - 1, 1'b0);  // R3 cleared on last poll
    run(8'h5A, 16'h7777, 8'h02, PM, 1'b0);      // R8 timeout
    run(8'h33, 16'h0101, 8'h04, 3, 1'b1);       // R10 start while busy
    // random
    for (int k = 0; k < 14; k++) begin
      logic [7:0] rid;
      rid = (($urandom % 4) == 0) ? 8'h00 : 8'($urandom);
      run(8'($urandom), 16'($urandom), rid, $urandom % (PM - 1), ($urandom % 3) == 0);
    end
    chk(viol == 0, "R9 hold while stalled", 32'(viol), 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog act=hung exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule